// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. Each accepted instruction brings a comparison kind, an operand-source choice, two 32-bit register values, a 16-bit immediate and a 5-bit spare field. The second operand is either the second register value or the immediate sign-extended to 32 bits. The block compares the first operand with this second operand, using either a signed or an unsigned comparison. If the condition holds, the block asks for an exception with cause code 13 and passes the spare field along with that request.

The result is held in a register, so it appears one cycle after the instruction is accepted. The exception control unit takes the request, stores the code and the spare field, and redirects to the handler. Decode, the exception registers and the redirect are not part of this block. A trap has no other effect: an instruction whose condition is false leaves the outputs in the idle state.

Top module: `trap_cond_unit`

## Requirements
- R1: Coming out of reset, `trap_req_o` is 0, `trap_code_o` is 0 and `trap_tag_o` is 0.
- R2: If `vld_i` is 0 in a cycle, `trap_req_o` is 0 in the following cycle.
- R3: `cond_i` selects the comparison: 0 is equal, 1 is not equal, 2 is signed greater-or-equal, 3 is unsigned greater-or-equal, 4 is signed less-than and 5 is unsigned less-than. The first operand is always `rs_i`.
- R4: When `use_imm_i` is 0, the second operand is `rt_i`.
- R5: When `use_imm_i` is 1, the second operand is `imm_i` sign-extended to 32 bits. This holds for the unsigned conditions 3 and 5 as well, where the extended value is then compared as unsigned.
- R6: Codes 6 and 7 on `cond_i` never raise a request.
- R7: If `vld_i` is 1 and the condition holds, then in the next cycle `trap_req_o` is 1 and `trap_code_o` is 13.
- R8: Whenever `trap_req_o` is 1, `trap_tag_o` equals the `tag_i` of the instruction that raised it. Whenever `trap_req_o` is 0, both `trap_code_o` and `trap_tag_o` are 0.
- R9: A valid instruction whose condition is false produces `trap_req_o` = 0 in the next cycle, with code 0 and tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Instruction valid strobe |
| cond_i | input | 3 | Comparison kind select |
| use_imm_i | input | 1 | 1: second operand is the immediate |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate, sign-extended when used |
| tag_i | input | 5 | Spare destination field of the instruction |
| trap_req_o | output | 1 | Trap request, one cycle after the valid strobe |
| trap_code_o | output | 5 | Exception cause code, 13 while a request is raised |
| trap_tag_o | output | 5 | Spare field carried with the request |

## Verification
All state sits in one output register stage, so an internal fault shows at the ports exactly one cycle after the stimulus that caused it. A wrong comparison or a wrong extension shows up as a request that is missing or extra on that cycle. Operand pairs are therefore chosen so that the signed and unsigned orderings disagree, and so that zero-extension and sign-extension give different answers. A stale or unmasked code or tag register shows up as a nonzero code or tag on a cycle with no request.

// File: rtl/trap_cond_unit.sv
module trap_cond_unit #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int TAG_W    = 5,
  parameter int CODE_W   = 5,
  parameter int TRAP_EXC = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [2:0]        cond_i,
  input  logic              use_imm_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              trap_req_o,
  output logic [CODE_W-1:0] trap_code_o,
  output logic [TAG_W-1:0]  trap_tag_o
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] opb;
  logic            eq, lts, ltu, hit;

  assign opb = use_imm_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : rt_i;
  assign eq  = (rs_i == opb);
  assign ltu = (rs_i < opb);
  assign lts = ($signed(rs_i) < $signed(opb));

  always_comb begin
    case (cond_i)
      3'd0:    hit = eq;
      3'd1:    hit = !eq;
      3'd2:    hit = !lts;
      3'd3:    hit = !ltu;
      3'd4:    hit = lts;
      3'd5:    hit = ltu;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trap_req_o  <= 1'b0;
      trap_code_o <= '0;
      trap_tag_o  <= '0;
    end else if (vld_i && hit) begin
      trap_req_o  <= 1'b1;
      trap_code_o <= CODE_W'(TRAP_EXC);
      trap_tag_o  <= tag_i;
    end else begin
      trap_req_o  <= 1'b0;
      trap_code_o <= '0;
      trap_tag_o  <= '0;
    end
  end

endmodule

module trap_cond_unit_chk #(
  parameter int TAG_W  = 5,
  parameter int CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic [2:0]        cond_i,
  input logic [TAG_W-1:0]  tag_i,
  input logic              trap_req_o,
  input logic [CODE_W-1:0] trap_code_o,
  input logic [TAG_W-1:0]  trap_tag_o
);

  assert_idle_no_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !trap_req_o);

  assert_bad_cond_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i[2:1] == 2'b11) |=> !trap_req_o);

  assert_code_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (trap_code_o == CODE_W'(13)));

  assert_tag_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && rst_ni) |=> (!trap_req_o || trap_tag_o == $past(tag_i)));

  assert_quiet_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_req_o |-> (trap_code_o == '0 && trap_tag_o == '0));

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!trap_req_o && trap_code_o == '0 && trap_tag_o == '0));

endmodule

bind trap_cond_unit trap_cond_unit_chk #(.TAG_W(TAG_W), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .cond_i(cond_i), .tag_i(tag_i),
  .trap_req_o(trap_req_o), .trap_code_o(trap_code_o), .trap_tag_o(trap_tag_o)
);

// File: tb/tb_trap_cond_unit.sv
module tb_trap_cond_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        vld = 0;
  logic [2:0]  cond = 0;
  logic        use_imm = 0;
  logic [31:0] rs = 0, rt = 0;
  logic [15:0] imm = 0;
  logic [4:0]  tag = 0;
  logic        req;
  logic [4:0]  code, otag;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {bit req; logic [4:0] tag; string rq;} exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  trap_cond_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .cond_i(cond), .use_imm_i(use_imm),
    .rs_i(rs), .rt_i(rt), .imm_i(imm), .tag_i(tag),
    .trap_req_o(req), .trap_code_o(code), .trap_tag_o(otag)
  );

  function automatic bit model(input bit v, input logic [2:0] c, input bit ui,
                               input logic [31:0] a, input logic [31:0] r, input logic [15:0] i);
    logic [31:0] b;
    b = ui ? {{16{i[15]}}, i} : r;
    if (!v) return 0;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) >= $signed(b);
      3: return a >= b;
      4: return $signed(a) < $signed(b);
      5: return a < b;
      default: return 0;
    endcase
  endfunction

  task automatic drive(input bit v, input logic [2:0] c, input bit ui, input logic [31:0] a,
                       input logic [31:0] r, input logic [15:0] i, input logic [4:0] t, input string rq);
    exp_t e;
    @(negedge clk);
    vld = v; cond = c; use_imm = ui; rs = a; rt = r; imm = i; tag = t;
    e.req = model(v, c, ui, a, r, i);
    e.tag = e.req ? t : 5'd0;
    e.rq = rq;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0 && !done) begin
        exp_t e;
        logic [4:0] ec;
        e = q.pop_front();
        ec = e.req ? 5'd13 : 5'd0;
        checks++;
        if (req !== e.req || code !== ec || otag !== e.tag) begin
          fails++;
          $display("FAIL %s: req/code/tag actual %0b/%0d/%0d expected %0b/%0d/%0d",
                   e.rq, req, code, otag, e.req, ec, e.tag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (req !== 0 || code !== 0 || otag !== 0) begin
      fails++;
      $display("FAIL R1: actual %0b/%0d/%0d expected 0/0/0", req, code, otag);
    end
    @(negedge clk); rst_n = 1;
    drive(0, 0, 0, 5, 5, 0, 7, "R2");
    drive(1, 0, 0, 32'h1234, 32'h1234, 0, 5'd9, "R3 R4 R7 R8 eq");
    drive(1, 0, 0, 32'h1234, 32'h1235, 0, 5'd9, "R9 eq false");
    drive(1, 1, 0, 1, 2, 0, 5'd3, "R3 ne");
    drive(1, 2, 0, 32'hFFFF_FFFF, 1, 0, 5'd4, "R3 ge signed false");
    drive(1, 3, 0, 32'hFFFF_FFFF, 1, 0, 5'd4, "R3 geu true");
    drive(1, 4, 0, 32'h8000_0000, 0, 0, 5'd31, "R3 lt signed true");
    drive(1, 5, 0, 32'h8000_0000, 0, 0, 5'd31, "R9 ltu false");
    drive(1, 0, 1, 32'hFFFF_FF9C, 0, 16'hFF9C, 5'd1, "R5 eq sext");
    drive(1, 3, 1, 32'h0001_0000, 0, 16'h8000, 5'd2, "R5 geu sext false");
    drive(1, 5, 1, 32'h0001_0000, 0, 16'h8000, 5'd2, "R5 ltu sext true");
    drive(1, 4, 1, 32'hFFFF_FFFF, 32'h0, 16'h0000, 5'd6, "R5 lt imm ignores rt");
    drive(1, 6, 0, 1, 1, 0, 5'd8, "R6 code 6");
    drive(1, 7, 1, 1, 1, 1, 5'd8, "R6 code 7");
    drive(0, 1, 0, 1, 2, 0, 5'd11, "R2 invalid");
    drive(1, 2, 0, 7, 7, 0, 5'd10, "R7 ge equal");
    for (int k = 0; k < 40; k++)
      drive(1, 3'(k % 6), 1'(k % 2), 32'(k * 32'h0913_7F31), 32'(k * 32'h8D2B_1003),
            16'(k * 16'h3A71), 5'(k), "R3 sweep");
    drive(0, 0, 0, 0, 0, 0, 0, "R2 drain");
    @(negedge clk); vld = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule